// File: doc/BRIEF.md
# Spike Intake Front-End

This block sits between an event-based vision sensor and a convolution engine. The sensor announces each pixel change as an address event on a four-phase request/acknowledge handshake. The block splits the address into column, row and polarity. It tags the event with a timestamp that is relative to the current sample, and queues the result for the engine downstream. The sender is assumed to share the block's clock. The request is therefore sampled directly, with no synchronizer.

The timestamp counter is loaded with its maximum value when a sample begins. It counts down by one on each tick and stops at zero, so earlier spikes carry larger values. When suppression is enabled, a per-pixel bitmap keeps only the first stored event of each pixel within a sample. Later events from that pixel are acknowledged and then discarded. The downstream controller watches the queue-empty flag and the counter-at-zero flag, and takes entries through a show-ahead pop port.

Top module: `spike_intake`

## Requirements
- R1: After reset, `ev_ack` is 0, `q_empty` is 1 and `ts_zero` is 1 (the counter resets to 0).
- R2: When `ev_ack` is low and `ev_req` is high, and the event can be taken, `ev_ack` rises one cycle later. It stays high while `ev_req` stays high and falls in the cycle after `ev_req` drops. Each handshake yields at most one event.
- R3: `ev_addr` is {row[10:6], column[5:1], polarity[0]}. A stored entry `q_data` is {timestamp[18:11], row[10:6], column[5:1], polarity[0]}.
- R4: `sample_start` loads the counter with 255. Each cycle with `tick` high decrements it by one, saturating at 0. An event carries the counter value of the cycle in which it is accepted.
- R5: `ts_zero` is high exactly when the counter holds 0.
- R6: The queue holds 32 entries in arrival order. `q_data` shows the oldest entry. `pop` removes it, and `pop` on an empty queue has no effect.
- R7: While the queue is full, an event that would be stored is not acknowledged. It is taken once a pop frees a slot.
- R8: With `gate_en` high, an event whose pixel (row, column, either polarity) was already stored in the current sample is acknowledged but not stored.
- R9: With `gate_en` low, every event is stored. Stored pixels are still recorded for later gating.
- R10: `sample_start` clears the pixel record. No event is accepted in a cycle with `sample_start` high.
- R11: An event dropped by gating is acknowledged even while the queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_req | input | 1 | Event request from the sensor |
| ev_addr | input | 11 | Event address: row, column, polarity |
| ev_ack | output | 1 | Event acknowledge to the sensor |
| tick | input | 1 | Time reference pulse, one decrement per high cycle |
| sample_start | input | 1 | Starts a new sample: reloads the counter and clears the pixel record |
| gate_en | input | 1 | Enables first-spike suppression |
| pop | input | 1 | Removes the oldest queued entry |
| q_data | output | 19 | Oldest queued entry |
| q_empty | output | 1 | Queue holds no entries |
| ts_zero | output | 1 | Timestamp counter is at zero |

## Verification
A behavioural reference model runs alongside the design and is compared with `ev_ack`, `q_empty`, `ts_zero` and the head entry on every clock. A wrong counter value appears in the timestamp field of the next stored event. A stale or cleared pixel bit appears as an entry that is missing or extra, seen once the queue drains to that point. A wrong fill count appears either as an acknowledge while the queue is full or as a stall with slots free, within one cycle of the request.

// File: rtl/spike_pkg.sv
package spike_pkg;
  typedef enum logic {
    HS_IDLE = 1'b0,
    HS_HOLD = 1'b1
  } hs_state_t;
endpackage

// File: rtl/spike_handshake.sv
module spike_handshake
  import spike_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic can_take,
  input  logic block,
  output logic ack,
  output logic accept
);
  hs_state_t state;

  assign accept = (state == HS_IDLE) && req && !block && can_take;
  assign ack    = (state == HS_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= HS_IDLE;
    end else begin
      case (state)
        HS_IDLE: if (accept) state <= HS_HOLD;
        HS_HOLD: if (!req)   state <= HS_IDLE;
        default:             state <= HS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spike_stamp.sv
module spike_stamp #(
  parameter int TS_BITS = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               tick,
  output logic [TS_BITS-1:0] ts,
  output logic               ts_zero
);
  localparam logic [TS_BITS-1:0] TS_MAX = {TS_BITS{1'b1}};
  logic [TS_BITS-1:0] ts_next;

  always_comb begin
    ts_next = ts;
    if (start)                        ts_next = TS_MAX;
    else if (tick && (ts != '0))      ts_next = ts - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ts      <= '0;
      ts_zero <= 1'b1;
    end else begin
      ts      <= ts_next;
      ts_zero <= (ts_next == '0);
    end
  end
endmodule

// File: rtl/spike_gate.sv
module spike_gate #(
  parameter int PIX_BITS = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clear,
  input  logic [PIX_BITS-1:0] pix,
  input  logic                mark,
  output logic                seen
);
  localparam int NPIX = 1 << PIX_BITS;
  logic [NPIX-1:0] bitmap;

  assign seen = bitmap[pix];

  always_ff @(posedge clk) begin
    if (rst || clear) bitmap <= '0;
    else if (mark)    bitmap[pix] <= 1'b1;
  end
endmodule

// File: rtl/spike_fifo.sv
module spike_fifo #(
  parameter int WIDTH = 19,
  parameter int DEPTH = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [WIDTH-1:0]           din,
  input  logic                       pop,
  output logic [WIDTH-1:0]           dout,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             pop_ok;

  assign pop_ok = pop && (count != '0);
  assign dout   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push)   wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop_ok) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/spike_intake.sv
module spike_intake #(
  parameter int X_BITS  = 5,
  parameter int Y_BITS  = 5,
  parameter int TS_BITS = 8,
  parameter int DEPTH   = 32,
  localparam int PIX_BITS = X_BITS + Y_BITS,
  localparam int ADDR_W   = PIX_BITS + 1,
  localparam int ENTRY_W  = ADDR_W + TS_BITS,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ev_req,
  input  logic [ADDR_W-1:0]  ev_addr,
  output logic               ev_ack,
  input  logic               tick,
  input  logic               sample_start,
  input  logic               gate_en,
  input  logic               pop,
  output logic [ENTRY_W-1:0] q_data,
  output logic               q_empty,
  output logic               ts_zero
);
  logic                polarity;
  logic [X_BITS-1:0]   col;
  logic [Y_BITS-1:0]   row;
  logic [PIX_BITS-1:0] pix;
  logic [TS_BITS-1:0]  ts_w;
  logic [CNT_W-1:0]    q_count;
  logic                seen_w, drop_w, full_w, can_take_w, accept_w, push_w;
  logic [ENTRY_W-1:0]  entry_w;

  // address decode
  assign polarity = ev_addr[0];
  assign col      = ev_addr[X_BITS:1];
  assign row      = ev_addr[ADDR_W-1:X_BITS+1];
  assign pix      = {row, col};

  assign full_w     = (q_count == CNT_W'(DEPTH));
  assign drop_w     = gate_en && seen_w;
  assign can_take_w = drop_w || !full_w;
  assign push_w     = accept_w && !drop_w;
  assign entry_w    = {ts_w, row, col, polarity};
  assign q_empty    = (q_count == '0);

  spike_handshake u_hs (
    .clk(clk), .rst(rst), .req(ev_req), .can_take(can_take_w),
    .block(sample_start), .ack(ev_ack), .accept(accept_w)
  );

  spike_stamp #(.TS_BITS(TS_BITS)) u_stamp (
    .clk(clk), .rst(rst), .start(sample_start), .tick(tick),
    .ts(ts_w), .ts_zero(ts_zero)
  );

  spike_gate #(.PIX_BITS(PIX_BITS)) u_gate (
    .clk(clk), .rst(rst), .clear(sample_start), .pix(pix),
    .mark(push_w), .seen(seen_w)
  );

  spike_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push_w), .din(entry_w),
    .pop(pop), .dout(q_data), .count(q_count)
  );
endmodule

// File: rtl/spike_intake_chk.sv
module spike_intake_chk #(
  parameter int TS_BITS = 8,
  parameter int DEPTH   = 32,
  parameter int CNT_W   = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               ev_req,
  input logic               ev_ack,
  input logic               sample_start,
  input logic               tick,
  input logic               q_empty,
  input logic               ts_zero,
  input logic               push,
  input logic               drop,
  input logic [CNT_W-1:0]   count,
  input logic [TS_BITS-1:0] ts
);
  a_r2_ack_hold: assert property (@(posedge clk) disable iff (rst)
    (ev_ack && ev_req) |=> ev_ack);
  a_r2_ack_release: assert property (@(posedge clk) disable iff (rst)
    (ev_ack && !ev_req) |=> !ev_ack);
  a_r7_full_stall: assert property (@(posedge clk) disable iff (rst)
    (!ev_ack && (count == CNT_W'(DEPTH)) && !drop) |=> !ev_ack);
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push |-> (count < CNT_W'(DEPTH)));
  a_r6_empty_pop: assert property (@(posedge clk) disable iff (rst)
    (q_empty && !push) |=> q_empty);
  a_r4_start_load: assert property (@(posedge clk) disable iff (rst)
    sample_start |=> (ts == {TS_BITS{1'b1}}));
  a_r4_decrement: assert property (@(posedge clk) disable iff (rst)
    (tick && !sample_start && (ts != '0)) |=> (ts == $past(ts) - 1'b1));
  a_r5_saturate: assert property (@(posedge clk) disable iff (rst)
    ((ts == '0) && !sample_start) |=> ((ts == '0) && ts_zero));
  a_r10_no_accept_on_start: assert property (@(posedge clk) disable iff (rst)
    (sample_start && !ev_ack) |=> !ev_ack);
endmodule

bind spike_intake spike_intake_chk #(
  .TS_BITS(TS_BITS), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .ev_req(ev_req), .ev_ack(ev_ack),
  .sample_start(sample_start), .tick(tick), .q_empty(q_empty),
  .ts_zero(ts_zero), .push(push_w), .drop(drop_w), .count(q_count), .ts(ts_w)
);

// File: tb/test_spike_intake.sv
module test_spike_intake;
  localparam int CLK_PERIOD = 10;
  localparam int QCAP = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ev_req = 1'b0;
  logic [10:0] ev_addr = '0;
  logic        ev_ack;
  logic        tick = 1'b0;
  logic        sample_start = 1'b0;
  logic        gate_en = 1'b0;
  logic        pop = 1'b0;
  logic [18:0] q_data;
  logic        q_empty;
  logic        ts_zero;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spike_intake i_spike_intake (
    .clk(clk), .rst(rst), .ev_req(ev_req), .ev_addr(ev_addr), .ev_ack(ev_ack),
    .tick(tick), .sample_start(sample_start), .gate_en(gate_en), .pop(pop),
    .q_data(q_data), .q_empty(q_empty), .ts_zero(ts_zero)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit          m_ack = 1'b0;
  int          m_ts = 0;
  bit          seen [1024];
  logic [18:0] mq [$];
  bit          m_live = 1'b0;

  always @(posedge clk) begin
    int  px;
    bit  drp, acc, popok;
    if (rst) begin
      m_ack = 1'b0; m_ts = 0; mq.delete(); m_live = 1'b1;
      foreach (seen[i]) seen[i] = 1'b0;
    end else begin
      px    = int'(ev_addr[10:1]);
      drp   = gate_en && seen[px];
      acc   = !m_ack && ev_req && !sample_start && (drp || mq.size() < QCAP);
      popok = pop && (mq.size() > 0);
      if (m_ack) begin
        if (!ev_req) m_ack = 1'b0;
      end else if (acc) m_ack = 1'b1;
      if (popok) void'(mq.pop_front());
      if (acc && !drp) begin
        mq.push_back({m_ts[7:0], ev_addr});
        seen[px] = 1'b1;
      end
      if (sample_start) begin
        m_ts = 255;
        foreach (seen[i]) seen[i] = 1'b0;
      end else if (tick && m_ts > 0) m_ts = m_ts - 1;
    end
  end

  always @(negedge clk) begin
    if (m_live && !rst && !done) begin
      chk(ev_ack == m_ack, "R2 ack per-cycle", int'(ev_ack), int'(m_ack));
      chk(q_empty == (mq.size() == 0), "R6 empty per-cycle", int'(q_empty), int'(mq.size() == 0));
      chk(ts_zero == (m_ts == 0), "R5 ts_zero per-cycle", int'(ts_zero), int'(m_ts == 0));
      if (mq.size() > 0)
        chk(q_data == mq[0], "R3 head per-cycle", int'(q_data), int'(mq[0]));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [10:0] mk(input int row, input int col, input int p);
    return {row[4:0], col[4:0], p[0]};
  endfunction

  task automatic send(input logic [10:0] a);
    @(negedge clk);
    ev_req = 1'b1; ev_addr = a;
    @(negedge clk);
    while (!ev_ack) @(negedge clk);
    ev_req = 1'b0;
    @(negedge clk);
    while (ev_ack) @(negedge clk);
  endtask

  task automatic pop_one();
    @(negedge clk); pop = 1'b1;
    @(negedge clk); pop = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic new_sample();
    @(negedge clk); sample_start = 1'b1;
    @(negedge clk); sample_start = 1'b0;
  endtask

  task automatic drain(output int n);
    n = 0;
    while (!q_empty) begin pop_one(); n++; end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(ev_ack == 1'b0, "R1 ack after reset", int'(ev_ack), 0);
    chk(q_empty == 1'b1, "R1 empty after reset", int'(q_empty), 1);
    chk(ts_zero == 1'b1, "R1 ts_zero after reset", int'(ts_zero), 1);

    new_sample();
    chk(ts_zero == 1'b0, "R5 counter loaded", int'(ts_zero), 0);
    send(mk(3, 7, 1));
    chk(q_data == {8'd255, 5'd3, 5'd7, 1'b1}, "R3 R4 first entry", int'(q_data),
        int'({8'd255, 5'd3, 5'd7, 1'b1}));
    pop_one();
    chk(q_empty == 1'b1, "R6 empty after pop", int'(q_empty), 1);

    ticks(3);
    send(mk(1, 2, 0));
    chk(q_data[18:11] == 8'd252, "R4 stamp after 3 ticks", int'(q_data[18:11]), 252);
    pop_one();

    // R6 ordering
    send(mk(4, 4, 0)); send(mk(5, 5, 1)); send(mk(6, 6, 0));
    for (int k = 4; k <= 6; k++) begin
      chk(q_data[10:1] == {k[4:0], k[4:0]}, "R6 arrival order", int'(q_data[10:1]),
          int'({k[4:0], k[4:0]}));
      pop_one();
    end

    // R8 gating on
    gate_en = 1'b1;
    send(mk(9, 9, 0)); send(mk(9, 9, 1));
    drain(n);
    chk(n == 1, "R8 repeat pixel dropped", n, 1);

    // R9 gating off
    gate_en = 1'b0;
    send(mk(9, 9, 1)); send(mk(9, 9, 0));
    drain(n);
    chk(n == 2, "R9 repeats kept when gating off", n, 2);

    // fill queue
    for (int k = 0; k < QCAP; k++) send(mk(k, 20, 0));
    chk(q_empty == 1'b0, "R6 queue filled", int'(q_empty), 0);
    // R11 dropped event acked while full
    gate_en = 1'b1;
    send(mk(0, 20, 1));
    chk(ev_ack == 1'b0, "R11 dropped event completed handshake", int'(ev_ack), 0);
    // R7 stall while full
    @(negedge clk); ev_req = 1'b1; ev_addr = mk(5, 30, 0);
    repeat (5) @(negedge clk);
    chk(ev_ack == 1'b0, "R7 no ack while full", int'(ev_ack), 0);
    pop_one();
    @(negedge clk);
    chk(ev_ack == 1'b1, "R7 ack after pop frees slot", int'(ev_ack), 1);
    ev_req = 1'b0;
    @(negedge clk);
    drain(n);
    chk(n == QCAP, "R7 R11 queue count after stall", n, QCAP);

    // R10 sample start clears record and blocks accept
    new_sample();
    send(mk(9, 9, 0)); send(mk(9, 9, 0));
    drain(n);
    chk(n == 1, "R10 record cleared by sample start", n, 1);
    @(negedge clk); ev_req = 1'b1; ev_addr = mk(12, 12, 1); sample_start = 1'b1;
    @(negedge clk);
    chk(ev_ack == 1'b0, "R10 no accept during sample start", int'(ev_ack), 0);
    sample_start = 1'b0;
    @(negedge clk);
    chk(ev_ack == 1'b1, "R10 accept after sample start", int'(ev_ack), 1);
    ev_req = 1'b0;
    @(negedge clk);
    pop_one();

    // R5 saturation
    ticks(260);
    chk(ts_zero == 1'b1, "R5 counter saturated", int'(ts_zero), 1);
    send(mk(2, 3, 1));
    chk(q_data[18:11] == 8'd0, "R4 stamp at zero", int'(q_data[18:11]), 0);
    pop_one();

    // R6 pop on empty
    pop_one();
    chk(q_empty == 1'b1, "R6 pop on empty ignored", int'(q_empty), 1);
    send(mk(7, 1, 0));
    chk(q_data == {8'd0, 5'd7, 5'd1, 1'b0}, "R6 entry after empty pop", int'(q_data),
        int'({8'd0, 5'd7, 5'd1, 1'b0}));
    pop_one();

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule